// File: doc/BRIEF.md
# Multicontext Row Configuration Store

This block keeps the configuration of a sixteen-row reconfigurable array in four complete, independent contexts. One context is active at a time. Its rows are read continuously, decoded and presented to the array. Any other context can be rewritten in the background while the array keeps computing from the active one. A switch command moves the array to another context on the next clock edge.

Rows arrive on a streaming write port. Each beat carries a 192-bit row word together with its target context and row number. Each beat replaces exactly one row of one context, so a context can be refreshed completely or only in part.

Inside a row word, every routing choice is held as a 3-bit index, which is cheaper than one bit per switch. At the output, each index is expanded into an 8-wire one-hot enable. The write port follows valid/ready rules:
- A beat transfers on a clock edge where both `wr_valid_i` and `wr_ready_o` are high.
- `wr_ready_o` is low while reset is applied.
- After reset, `wr_ready_o` stays high, so the store never applies back-pressure.
- A beat that cannot be stored is still consumed, and it is reported on `wr_err_o`.

Top module: `mcfg_store`

## Requirements
- R1: After reset, context 0 is active, every stored row word is zero (so every decoded group shows index 0, i.e. its bit 0 set), `row_valid_o` is zero and `wr_err_o` is low.
- R2: A cycle with `sw_valid_i` high makes `sw_ctx_i` the active context from the next clock edge. `act_ctx_o` and `cfg_sel_o` both reflect the new context one cycle after the command.
- R3: An accepted beat stores all 192 bits of `wr_data_i` into row `wr_row_i` of context `wr_ctx_i`. The stored word becomes visible on `cfg_sel_o` once that context is made active.
- R4: A beat aimed at the active context, or at the context that a switch in the same cycle selects, is dropped. In that case `wr_err_o` is high for exactly the next cycle, and the active outputs keep their value.
- R5: Writes to inactive contexts never disturb `cfg_sel_o`, so the outputs change only in the cycle after a switch. One beat is taken per cycle, so all 16 rows of a context load in 16 consecutive cycles.
- R6: Rewriting some rows of a context leaves every other row of that context at its previous value.
- R7: Decode rule:
  - Field k of a row word is bits [3k+2:3k], with k from 0 to 63.
  - Row r, field k appears at `cfg_sel_o[r*512 + k*8 +: 8]`.
  - Exactly one of those 8 bits is set, namely the bit numbered by the field value.
- R8: `row_valid_o` shows the written-rows bitmap of the active context:
  - An accepted write to row r sets bit r of its context's bitmap.
  - `clr_valid_i` clears the bitmap of context `clr_ctx_i` and leaves the stored data untouched.
  - If a clear and an accepted write hit the same context in one cycle, the written row's bit ends up set.
- R9: `wr_ready_o` is low during reset and high in every cycle afterwards. A beat counts only when valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Row write beat present |
| wr_ready_o | output | 1 | Store can take a beat |
| wr_ctx_i | input | 2 | Target context of the beat |
| wr_row_i | input | 4 | Target row of the beat |
| wr_data_i | input | 192 | Row configuration word |
| wr_err_o | output | 1 | One-cycle pulse after a dropped beat |
| sw_valid_i | input | 1 | Switch active context |
| sw_ctx_i | input | 2 | Context to make active |
| clr_valid_i | input | 1 | Clear a context's written-rows bitmap |
| clr_ctx_i | input | 2 | Context whose bitmap is cleared |
| act_ctx_o | output | 2 | Currently active context |
| row_valid_o | output | 16 | Written-rows bitmap of the active context |
| cfg_sel_o | output | 8192 | Decoded one-hot switch enables, 512 per row |

## Verification
- A corrupted row of an inactive context stays hidden until that context is selected. The bench therefore switches to every context it has loaded and compares all 16 decoded rows against a model.
- A write that wrongly lands in the active context shows at once, one cycle later, as a change on `cfg_sel_o` and a missing `wr_err_o` pulse. Both are sampled straight after every rejected beat.
- A wrong active-context register changes `act_ctx_o` and every output group in the cycle after a switch, so switch timing is checked in that exact cycle.
- Bitmap faults appear on `row_valid_o` as soon as the affected context is active.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  localparam int unsigned DEF_ROWS  = 16;
  localparam int unsigned DEF_CTXS  = 4;
  localparam int unsigned DEF_ROW_W = 192;
  localparam int unsigned DEF_SEL_W = 3;

  // classification of one incoming write beat
  typedef enum logic [1:0] {
    BEAT_IDLE   = 2'd0,
    BEAT_STORE  = 2'd1,
    BEAT_REJECT = 2'd2
  } beat_kind_e;
endpackage

// File: rtl/mcfg_dec.sv
module mcfg_dec #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned FAN  = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] idx_i,
  output logic [FAN-1:0]   onehot_o
);
  always_comb begin
    onehot_o = '0;
    onehot_o[idx_i] = 1'b1;
  end
endmodule

// File: rtl/mcfg_ctx_ctrl.sv
module mcfg_ctx_ctrl
  import mcfg_pkg::*;
#(
  parameter int unsigned CTXS  = 4,
  localparam int unsigned CTX_W = $clog2(CTXS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid_i,
  input  logic [CTX_W-1:0] wr_ctx_i,
  input  logic             sw_valid_i,
  input  logic [CTX_W-1:0] sw_ctx_i,
  output logic             wr_ready_o,
  output logic             wr_store_o,
  output logic             wr_err_o,
  output logic [CTX_W-1:0] act_ctx_o
);
  logic [CTX_W-1:0] act_q;
  logic             rdy_q;
  logic             err_q;
  logic             hits_live;
  beat_kind_e       kind;

  // a beat collides with the context driving the array now or next cycle
  assign hits_live = (wr_ctx_i == act_q) || (sw_valid_i && (wr_ctx_i == sw_ctx_i));

  always_comb begin
    kind = BEAT_IDLE;
    if (wr_valid_i && rdy_q) kind = hits_live ? BEAT_REJECT : BEAT_STORE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      rdy_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      err_q <= (kind == BEAT_REJECT);
      if (sw_valid_i) act_q <= sw_ctx_i;
    end
  end

  assign wr_ready_o = rdy_q;
  assign wr_store_o = (kind == BEAT_STORE);
  assign wr_err_o   = err_q;
  assign act_ctx_o  = act_q;

  assert_switch_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid_i |=> (act_ctx_o == $past(sw_ctx_i)));

  assert_reject_live_ctx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_ready_o && (wr_ctx_i == act_ctx_o)) |=> wr_err_o);

  assert_err_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |-> $past(wr_valid_i));

  assert_ready_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_ready_o);
endmodule

// File: rtl/mcfg_bank.sv
module mcfg_bank #(
  parameter int unsigned CTXS  = 4,
  parameter int unsigned ROWS  = 16,
  parameter int unsigned ROW_W = 192,
  localparam int unsigned CTX_W = $clog2(CTXS),
  localparam int unsigned RID_W = $clog2(ROWS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [CTX_W-1:0]      wctx_i,
  input  logic [RID_W-1:0]      wrow_i,
  input  logic [ROW_W-1:0]      wdata_i,
  input  logic                  clr_i,
  input  logic [CTX_W-1:0]      clr_ctx_i,
  input  logic [CTX_W-1:0]      rd_ctx_i,
  output logic [ROWS*ROW_W-1:0] rd_rows_o,
  output logic [ROWS-1:0]       rd_valid_o
);
  logic [ROW_W-1:0] mem  [CTXS][ROWS];
  logic [ROWS-1:0]  vmap [CTXS];

  // write side: one row of one context per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CTXS; c++) begin
        for (int r = 0; r < ROWS; r++) mem[c][r] <= '0;
      end
    end else if (we_i) begin
      mem[wctx_i][wrow_i] <= wdata_i;
    end
  end

  // written-rows bitmap; a same-cycle write overrides the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CTXS; c++) vmap[c] <= '0;
    end else begin
      if (clr_i) vmap[clr_ctx_i] <= '0;
      if (we_i)  vmap[wctx_i][wrow_i] <= 1'b1;
    end
  end

  // read side: every row of the selected context, independent of the write side
  for (genvar r = 0; r < ROWS; r++) begin : g_rd
    assign rd_rows_o[r*ROW_W +: ROW_W] = mem[rd_ctx_i][r];
  end
  assign rd_valid_o = vmap[rd_ctx_i];
endmodule

// File: rtl/mcfg_store.sv
module mcfg_store
  import mcfg_pkg::*;
#(
  parameter int unsigned ROWS  = DEF_ROWS,
  parameter int unsigned CTXS  = DEF_CTXS,
  parameter int unsigned ROW_W = DEF_ROW_W,
  parameter int unsigned SEL_W = DEF_SEL_W
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        wr_valid_i,
  output logic                                        wr_ready_o,
  input  logic [$clog2(CTXS)-1:0]                     wr_ctx_i,
  input  logic [$clog2(ROWS)-1:0]                     wr_row_i,
  input  logic [ROW_W-1:0]                            wr_data_i,
  output logic                                        wr_err_o,
  input  logic                                        sw_valid_i,
  input  logic [$clog2(CTXS)-1:0]                     sw_ctx_i,
  input  logic                                        clr_valid_i,
  input  logic [$clog2(CTXS)-1:0]                     clr_ctx_i,
  output logic [$clog2(CTXS)-1:0]                     act_ctx_o,
  output logic [ROWS-1:0]                             row_valid_o,
  output logic [ROWS*(ROW_W/SEL_W)*(1<<SEL_W)-1:0]    cfg_sel_o
);
  localparam int unsigned FIELDS    = ROW_W / SEL_W;
  localparam int unsigned FAN       = 1 << SEL_W;
  localparam int unsigned ROW_OUT_W = FIELDS * FAN;

  logic                    store;
  logic [ROWS*ROW_W-1:0]   live_rows;

  mcfg_ctx_ctrl #(.CTXS(CTXS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (wr_valid_i),
    .wr_ctx_i   (wr_ctx_i),
    .sw_valid_i (sw_valid_i),
    .sw_ctx_i   (sw_ctx_i),
    .wr_ready_o (wr_ready_o),
    .wr_store_o (store),
    .wr_err_o   (wr_err_o),
    .act_ctx_o  (act_ctx_o)
  );

  mcfg_bank #(.CTXS(CTXS), .ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (store),
    .wctx_i     (wr_ctx_i),
    .wrow_i     (wr_row_i),
    .wdata_i    (wr_data_i),
    .clr_i      (clr_valid_i),
    .clr_ctx_i  (clr_ctx_i),
    .rd_ctx_i   (act_ctx_o),
    .rd_rows_o  (live_rows),
    .rd_valid_o (row_valid_o)
  );

  // expand every stored routing index into its one-hot wire enable
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar k = 0; k < FIELDS; k++) begin : g_fld
      mcfg_dec #(.SEL_W(SEL_W)) u_dec (
        .idx_i    (live_rows[r*ROW_W + k*SEL_W +: SEL_W]),
        .onehot_o (cfg_sel_o[r*ROW_OUT_W + k*FAN +: FAN])
      );
    end
  end

  assert_quiet_without_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_valid_i |=> $stable(cfg_sel_o));

  assert_clear_live_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid_i && (clr_ctx_i == act_ctx_o) && !sw_valid_i) |=> (row_valid_o == '0));
endmodule

// File: tb/mcfg_store_tb.sv
`timescale 1ns/1ps
module mcfg_store_tb;
  localparam int ROWS = 16;
  localparam int CTXS = 4;
  localparam int ROW_W = 192;
  localparam int FIELDS = 64;
  localparam int ROW_OUT_W = 512;
  localparam int OUT_W = ROWS * ROW_OUT_W;

  // vector: [11:10] context, [9:6] row, [5:0] data seed
  localparam logic [11:0] VEC [10] = '{
    {2'd1, 4'd0,  6'd1}, {2'd1, 4'd5,  6'd2}, {2'd0, 4'd3,  6'd3},
    {2'd2, 4'd15, 6'd4}, {2'd3, 4'd7,  6'd5}, {2'd1, 4'd5,  6'd6},
    {2'd2, 4'd0,  6'd7}, {2'd0, 4'd0,  6'd8}, {2'd3, 4'd8,  6'd9},
    {2'd1, 4'd15, 6'd10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid_i = 1'b0;
  logic wr_ready_o;
  logic [1:0] wr_ctx_i = '0;
  logic [3:0] wr_row_i = '0;
  logic [ROW_W-1:0] wr_data_i = '0;
  logic wr_err_o;
  logic sw_valid_i = 1'b0;
  logic [1:0] sw_ctx_i = '0;
  logic clr_valid_i = 1'b0;
  logic [1:0] clr_ctx_i = '0;
  logic [1:0] act_ctx_o;
  logic [ROWS-1:0] row_valid_o;
  logic [OUT_W-1:0] cfg_sel_o;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [ROW_W-1:0] m_mem [CTXS][ROWS];
  logic [ROWS-1:0]  m_vld [CTXS];
  logic [1:0]       m_act;
  logic             m_err;

  always #5 clk = ~clk;

  mcfg_store u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .wr_ctx_i(wr_ctx_i), .wr_row_i(wr_row_i), .wr_data_i(wr_data_i), .wr_err_o(wr_err_o),
    .sw_valid_i(sw_valid_i), .sw_ctx_i(sw_ctx_i), .clr_valid_i(clr_valid_i),
    .clr_ctx_i(clr_ctx_i), .act_ctx_o(act_ctx_o), .row_valid_o(row_valid_o),
    .cfg_sel_o(cfg_sel_o)
  );

  function automatic logic [ROW_W-1:0] pat(input int s);
    logic [ROW_W-1:0] w;
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a;
      a = 32'(s) * 32'h9E3779B9 + 32'(i) * 32'h7F4A7C15;
      w[i*32 +: 32] = a ^ 32'h5BD1E995;
    end
    return w;
  endfunction

  function automatic logic [OUT_W-1:0] expect_out(input logic [1:0] c);
    logic [OUT_W-1:0] v;
    v = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < FIELDS; k++) begin
        v[r*ROW_OUT_W + k*8 + int'(m_mem[c][r][k*3 +: 3])] = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R7: compare all decoded groups of the active context with the model
  task automatic chk_cfg(input string req);
    logic [OUT_W-1:0] e;
    bit ok;
    e = expect_out(m_act);
    ok = 1'b1;
    checks++;
    for (int r = 0; r < ROWS && ok; r++) begin
      for (int k = 0; k < FIELDS && ok; k++) begin
        if (cfg_sel_o[r*ROW_OUT_W + k*8 +: 8] !== e[r*ROW_OUT_W + k*8 +: 8]) begin
          ok = 1'b0;
          bad++;
          $display("FAIL %s row=%0d field=%0d actual=%0h expected=%0h", req, r, k,
                   cfg_sel_o[r*ROW_OUT_W + k*8 +: 8], e[r*ROW_OUT_W + k*8 +: 8]);
        end
      end
    end
  endtask

  // one clock of stimulus: drive at a falling edge, return at the next falling edge
  task automatic step(input bit wv, input logic [1:0] wc, input logic [3:0] wr,
                      input logic [ROW_W-1:0] wd, input bit sv, input logic [1:0] sc,
                      input bit cv, input logic [1:0] cc);
    bit hit;
    wr_valid_i = wv; wr_ctx_i = wc; wr_row_i = wr; wr_data_i = wd;
    sw_valid_i = sv; sw_ctx_i = sc; clr_valid_i = cv; clr_ctx_i = cc;
    hit = (wc == m_act) || (sv && (wc == sc));
    if (cv) m_vld[cc] = '0;
    if (wv && !hit) begin
      m_mem[wc][wr] = wd;
      m_vld[wc][wr] = 1'b1;
    end
    m_err = wv && hit;
    if (sv) m_act = sc;
    @(negedge clk);
    wr_valid_i = 1'b0; sw_valid_i = 1'b0; clr_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] c, input logic [3:0] r, input logic [ROW_W-1:0] d);
    step(1'b1, c, r, d, 1'b0, 2'd0, 1'b0, 2'd0);
  endtask

  task automatic sw(input logic [1:0] c);
    step(1'b0, 2'd0, 4'd0, '0, 1'b1, c, 1'b0, 2'd0);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    #(10 * 100000);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < CTXS; c++) begin
      m_vld[c] = '0;
      for (int r = 0; r < ROWS; r++) m_mem[c][r] = '0;
    end
    m_act = '0;
    m_err = 1'b0;

    repeat (3) @(negedge clk);
    chk("R9 ready low in reset", 64'(wr_ready_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 ready high after reset", 64'(wr_ready_o), 64'd1);
    chk("R1 active ctx after reset", 64'(act_ctx_o), 64'd0);
    chk("R1 bitmap after reset", 64'(row_valid_o), 64'd0);
    chk("R1 no error after reset", 64'(wr_err_o), 64'd0);
    chk_cfg("R1 zero words decode to index 0");

    // table walk: background writes while context 0 drives the array
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][11:10], VEC[i][9:6], pat(int'(VEC[i][5:0])));
      chk("R4 error pulse matches target", 64'(wr_err_o), 64'(m_err));
      chk_cfg("R5 active outputs untouched by writes");
    end
    @(negedge clk);
    chk("R4 error lasts one cycle", 64'(wr_err_o), 64'd0);

    for (int c = 1; c < CTXS; c++) begin
      chk("R2 old ctx before switch", 64'(act_ctx_o), 64'(c - 1));
      sw(2'(c));
      chk("R2 ctx one cycle after switch", 64'(act_ctx_o), 64'(c));
      chk_cfg("R3 stored rows visible after switch");
      chk("R8 bitmap of loaded ctx", 64'(row_valid_o), 64'(m_vld[c]));
    end

    // full reload of context 2 in 16 back-to-back beats while context 3 is live
    for (int r = 0; r < ROWS; r++) begin
      chk("R9 ready during burst", 64'(wr_ready_o), 64'd1);
      wr(2'd2, 4'(r), pat(100 + r));
      chk("R5 no error on burst beat", 64'(wr_err_o), 64'd0);
    end
    sw(2'd2);
    chk_cfg("R5 full reload in 16 cycles");
    chk("R8 all rows marked", 64'(row_valid_o), 64'hFFFF);

    // partial rewrite of context 2 from context 0
    sw(2'd0);
    wr(2'd2, 4'd2, pat(200));
    wr(2'd2, 4'd9, pat(201));
    wr(2'd2, 4'd13, pat(202));
    sw(2'd2);
    chk_cfg("R6 partial rewrite keeps other rows");

    // write to live context is dropped and outputs hold
    wr(2'd2, 4'd4, pat(300));
    chk("R4 live-ctx write flagged", 64'(wr_err_o), 64'd1);
    chk_cfg("R4 live-ctx write ignored");

    // write aimed at the context being switched to in the same cycle
    step(1'b1, 2'd1, 4'd1, pat(301), 1'b1, 2'd1, 1'b0, 2'd0);
    chk("R4 write to incoming ctx flagged", 64'(wr_err_o), 64'd1);
    chk_cfg("R4 incoming ctx not written");

    // clear of context 3 while row 4 of it is written in the same cycle
    step(1'b1, 2'd3, 4'd4, pat(400), 1'b0, 2'd0, 1'b1, 2'd3);
    sw(2'd3);
    chk("R8 write wins over clear", 64'(row_valid_o), 64'h0010);
    chk_cfg("R8 clear keeps data");

    // clear of the live bitmap
    step(1'b0, 2'd0, 4'd0, '0, 1'b0, 2'd0, 1'b1, 2'd3);
    chk("R8 live bitmap cleared", 64'(row_valid_o), 64'd0);
    chk_cfg("R7 decode after clear");

    done = 1'b1;
    report();
    $finish;
  end
endmodule